// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block is the operand store for a 16-bit processor datapath. It keeps eight 16-bit registers. Four of them are general registers, and each of those can also be reached as two independent 8-bit halves. The other four are pointer and index registers, and they can only be reached as whole words. Two read ports and one write port each carry a 3-bit register index and a size bit, so each port can do a word access or a byte access.

The byte views and the word views share the same storage. A byte write therefore changes one half of a general register and leaves the other half untouched. A separate double-width write path takes a 32-bit multiply or divide result and stores it in one cycle: the upper word goes to the data register and the lower word goes to the accumulator. Read data is registered, so it appears one cycle after the index is presented.

Top module: `gp_regfile`

## Requirements
- R1: While the synchronous active-high reset is sampled high, all eight registers clear to zero. Both read outputs are zero in the cycle after a reset edge.
- R2: For a word access (size bit 0), index 0..7 selects the accumulator, count, data, base, stack pointer, base pointer, source index and destination index registers, in that order.
- R3: For a byte access (size bit 1), indices 0..3 select the low bytes of the accumulator, count, data and base registers. Indices 4..7 select the high bytes of the same four registers, in the same order.
- R4: A byte read returns the selected byte in bits 7:0 of the read port, with bits 15:8 zero.
- R5: A byte write stores bits 7:0 of the write data into the addressed half only. The other half of that register and every other register keep their values.
- R6: Each read port returns data one clock after its index is sampled. The data reflects the register contents before any write made on that same edge.
- R7: When the double-width write enable is high, the same edge stores bits 31:16 of the wide data into the data register (word index 2) and bits 15:0 into the accumulator (word index 0).
- R8: If the normal write targets the accumulator or the data register, or either half of them, in a cycle with a double-width write, the double-width value is the one stored. A normal write to any other register in that cycle still takes effect.
- R9: The two read ports work independently. They may address the same register with different sizes in the same cycle.
- R10: With both write enables low, no register changes, whatever the write index, size and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_byte | input | 1 | Read port 0 size: 1 = byte, 0 = word |
| rd0_data | output | 16 | Read port 0 registered data |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_byte | input | 1 | Read port 1 size: 1 = byte, 0 = word |
| rd1_data | output | 16 | Read port 1 registered data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 3 | Normal write register index |
| wr_byte | input | 1 | Normal write size: 1 = byte, 0 = word |
| wr_data | input | 16 | Normal write data; bits 7:0 are used for a byte write |
| wide_en | input | 1 | Double-width result write enable |
| wide_data | input | 32 | Double-width result: upper word to data register, lower word to accumulator |

## Verification
A wrong half-enable or a wrong index decode leaves a corrupted register that stays hidden until some port reads it. The bench therefore compares both read ports against a reference model on every clock, while random and directed traffic keeps reading all registers. A corruption then shows up within one cycle of the first read that touches the damaged half. Wide-write priority and zero-extension mistakes are different: they appear on the very next registered read after the offending edge.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  localparam int HALF_W    = 8;
  localparam int NUM_REGS  = 8;
  localparam int NUM_SPLIT = 4;
  localparam int WIDE_LO   = 0;
  localparam int WIDE_HI   = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } lane_we_t;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int NUM_REGS  = 8,
  parameter int NUM_SPLIT = 4,
  parameter int HALF_W    = 8,
  parameter int WIDE_LO   = 0,
  parameter int WIDE_HI   = 2,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int WORD_W   = 2 * HALF_W
) (
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic                             wr_byte,
  input  logic [WORD_W-1:0]                wr_data,
  input  logic                             wide_en,
  input  logic [2*WORD_W-1:0]              wide_data,
  output logic [NUM_REGS-1:0]              lo_we,
  output logic [NUM_REGS-1:0]              hi_we,
  output logic [NUM_REGS-1:0][HALF_W-1:0]  lo_wd,
  output logic [NUM_REGS-1:0][HALF_W-1:0]  hi_wd
);
  import gprf_pkg::*;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    lane_we_t en;

    always_comb begin
      en = '0;
      if (wr_en) begin
        if (!wr_byte) begin
          if (wr_idx == IDX_W'(r)) en = '{hi: 1'b1, lo: 1'b1};
        end else if (r < NUM_SPLIT) begin
          if (wr_idx == IDX_W'(r))             en.lo = 1'b1;
          if (wr_idx == IDX_W'(r + NUM_SPLIT)) en.hi = 1'b1;
        end
      end
      lo_wd[r] = wr_data[HALF_W-1:0];
      hi_wd[r] = wr_byte ? wr_data[HALF_W-1:0] : wr_data[WORD_W-1:HALF_W];
      if (wide_en && (r == WIDE_LO)) begin
        en       = '{hi: 1'b1, lo: 1'b1};
        lo_wd[r] = wide_data[HALF_W-1:0];
        hi_wd[r] = wide_data[WORD_W-1:HALF_W];
      end
      if (wide_en && (r == WIDE_HI)) begin
        en       = '{hi: 1'b1, lo: 1'b1};
        lo_wd[r] = wide_data[WORD_W+HALF_W-1:WORD_W];
        hi_wd[r] = wide_data[2*WORD_W-1:WORD_W+HALF_W];
      end
      lo_we[r] = en.lo;
      hi_we[r] = en.hi;
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int NUM_REGS = 8,
  parameter int HALF_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_REGS-1:0]             we,
  input  logic [NUM_REGS-1:0][HALF_W-1:0] wd,
  output logic [NUM_REGS-1:0][HALF_W-1:0] q
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)        q[r] <= '0;
      else if (we[r]) q[r] <= wd[r];
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int NUM_REGS  = 8,
  parameter int NUM_SPLIT = 4,
  parameter int HALF_W    = 8,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int WORD_W   = 2 * HALF_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            is_byte,
  input  logic [NUM_REGS-1:0][HALF_W-1:0] lo_q,
  input  logic [NUM_REGS-1:0][HALF_W-1:0] hi_q,
  output logic [WORD_W-1:0]               rdata
);
  logic [IDX_W-1:0]  hsel;
  logic [WORD_W-1:0] sel;

  always_comb begin
    hsel = idx - IDX_W'(NUM_SPLIT);
    if (!is_byte)                    sel = {hi_q[idx], lo_q[idx]};
    else if (idx < IDX_W'(NUM_SPLIT)) sel = {{HALF_W{1'b0}}, lo_q[idx]};
    else                             sel = {{HALF_W{1'b0}}, hi_q[hsel]};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end

  // R4
  byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
    $past(is_byte) |-> (rdata[WORD_W-1:HALF_W] == '0));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (rdata == '0));
endmodule

// File: rtl/gp_regfile.sv
module gp_regfile #(
  parameter int HALF_W    = gprf_pkg::HALF_W,
  parameter int NUM_REGS  = gprf_pkg::NUM_REGS,
  parameter int NUM_SPLIT = gprf_pkg::NUM_SPLIT,
  parameter int WIDE_LO   = gprf_pkg::WIDE_LO,
  parameter int WIDE_HI   = gprf_pkg::WIDE_HI,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int WORD_W   = 2 * HALF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    rd0_idx,
  input  logic                rd0_byte,
  output logic [WORD_W-1:0]   rd0_data,
  input  logic [IDX_W-1:0]    rd1_idx,
  input  logic                rd1_byte,
  output logic [WORD_W-1:0]   rd1_data,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_byte,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                wide_en,
  input  logic [2*WORD_W-1:0] wide_data
);
  logic [NUM_REGS-1:0]             lo_we, hi_we;
  logic [NUM_REGS-1:0][HALF_W-1:0] lo_wd, hi_wd, lo_q, hi_q;

  rf_wr_decode #(
    .NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT), .HALF_W(HALF_W),
    .WIDE_LO(WIDE_LO), .WIDE_HI(WIDE_HI)
  ) u_dec (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
    .wide_en(wide_en), .wide_data(wide_data),
    .lo_we(lo_we), .hi_we(hi_we), .lo_wd(lo_wd), .hi_wd(hi_wd)
  );

  rf_bank #(.NUM_REGS(NUM_REGS), .HALF_W(HALF_W)) u_lo (
    .clk(clk), .rst(rst), .we(lo_we), .wd(lo_wd), .q(lo_q)
  );

  rf_bank #(.NUM_REGS(NUM_REGS), .HALF_W(HALF_W)) u_hi (
    .clk(clk), .rst(rst), .we(hi_we), .wd(hi_wd), .q(hi_q)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT), .HALF_W(HALF_W)) u_rd0 (
    .clk(clk), .rst(rst), .idx(rd0_idx), .is_byte(rd0_byte),
    .lo_q(lo_q), .hi_q(hi_q), .rdata(rd0_data)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT), .HALF_W(HALF_W)) u_rd1 (
    .clk(clk), .rst(rst), .idx(rd1_idx), .is_byte(rd1_byte),
    .lo_q(lo_q), .hi_q(hi_q), .rdata(rd1_data)
  );

  // R7
  wide_hi_chk: assert property (@(posedge clk) disable iff (rst)
    wide_en |=> ({hi_q[WIDE_HI], lo_q[WIDE_HI]} == $past(wide_data[2*WORD_W-1:WORD_W])));

  // R8
  wide_lo_chk: assert property (@(posedge clk) disable iff (rst)
    wide_en |=> ({hi_q[WIDE_LO], lo_q[WIDE_LO]} == $past(wide_data[WORD_W-1:0])));

  // R5
  byte_keep_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_byte && !wide_en && (wr_idx < IDX_W'(NUM_SPLIT)))
      |=> (hi_q[$past(wr_idx)] == $past(hi_q[wr_idx])));

  // R10
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !wide_en) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: tb/sim_gp_regfile.sv
module sim_gp_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic        rd0_byte = 1'b0, rd1_byte = 1'b0, wr_en = 1'b0, wr_byte = 1'b0, wide_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] wide_data = '0;
  logic [15:0] rd0_data, rd1_data;

  int checks = 0;
  int bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic [15:0] m [8];
  logic [15:0] exp0 = '0, exp1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_regfile u0 (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_byte(rd0_byte), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_byte(rd1_byte), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
    .wide_en(wide_en), .wide_data(wide_data)
  );

  function automatic logic [15:0] view(input logic [2:0] i, input logic b);
    if (!b)     return m[i];
    if (i < 4)  return {8'h00, m[i][7:0]};
    return {8'h00, m[i-3'd4][15:8]};
  endfunction

  // Reference model: read before write, then normal write, then wide write on top.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) m[i] = '0;
      exp0 = '0;
      exp1 = '0;
    end else begin
      exp0 = view(rd0_idx, rd0_byte);
      exp1 = view(rd1_idx, rd1_byte);
      if (wr_en) begin
        if (!wr_byte)        m[wr_idx] = wr_data;
        else if (wr_idx < 4) m[wr_idx][7:0] = wr_data[7:0];
        else                 m[wr_idx-3'd4][15:8] = wr_data[7:0];
      end
      if (wide_en) begin
        m[0] = wide_data[15:0];
        m[2] = wide_data[31:16];
      end
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (rd0_data !== exp0) begin
      bad++;
      $display("FAIL %s port0 got=%h exp=%h", tag, rd0_data, exp0);
    end
    checks++;
    if (rd1_data !== exp1) begin
      bad++;
      $display("FAIL %s port1 got=%h exp=%h", tag, rd1_data, exp1);
    end
  endtask

  task automatic step(input logic r, input string tag,
                      input logic we, input logic [2:0] wi, input logic wb, input logic [15:0] wd,
                      input logic xe, input logic [31:0] xd,
                      input logic [2:0] a0, input logic b0, input logic [2:0] a1, input logic b1);
    @(negedge clk);
    compare(cur_tag);
    cur_tag = tag;
    rst = r; wr_en = we; wr_idx = wi; wr_byte = wb; wr_data = wd;
    wide_en = xe; wide_data = xd;
    rd0_idx = a0; rd0_byte = b0; rd1_idx = a1; rd1_byte = b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // R1: writes under reset are discarded, outputs zero
    step(1, "R1", 1, 3'd0, 0, 16'h1234, 1, 32'hDEADBEEF, 3'd0, 0, 3'd2, 0);
    step(1, "R1", 1, 3'd3, 0, 16'h5555, 0, '0, 3'd3, 0, 3'd0, 1);
    step(0, "R1", 0, 3'd0, 0, 16'h0, 0, '0, 3'd0, 0, 3'd2, 0);
    // R2: word writes to all eight, reading back the written index (R6 old value)
    for (int i = 0; i < 8; i++)
      step(0, "R6", 1, 3'(i), 0, 16'hA000 + 16'(i * 16'h0111), 0, '0, 3'(i), 0, 3'((i + 7) % 8), 0);
    for (int i = 0; i < 8; i++)
      step(0, "R2", 0, 3'd0, 0, 16'hFFFF, 0, '0, 3'(i), 0, 3'(7 - i), 0);
    // R5: byte writes to each byte index, upper write-data bits must be ignored
    for (int i = 0; i < 8; i++)
      step(0, "R5", 1, 3'(i), 1, {8'hEE, 8'h10 + 8'(i)}, 0, '0, 3'(i & 3), 0, 3'(i), 1);
    // R3 / R4: byte reads of all eight halves, word reads on port 1
    for (int i = 0; i < 8; i++)
      step(0, "R3", 0, 3'd0, 0, 16'h0, 0, '0, 3'(i), 1, 3'(i), 0);
    for (int i = 0; i < 4; i++)
      step(0, "R4", 0, 3'd0, 0, 16'h0, 0, '0, 3'(i + 4), 1, 3'(i), 1);
    // R6: read-during-write returns old value, next cycle returns new
    step(0, "R6", 1, 3'd1, 0, 16'hBEEF, 0, '0, 3'd1, 0, 3'd5, 1);
    step(0, "R6", 0, 3'd0, 0, 16'h0, 0, '0, 3'd1, 0, 3'd5, 1);
    // R9: same register on both ports at different sizes
    step(0, "R9", 0, 3'd0, 0, 16'h0, 0, '0, 3'd1, 0, 3'd5, 1);
    step(0, "R9", 0, 3'd0, 0, 16'h0, 0, '0, 3'd4, 0, 3'd4, 0);
    // R7: wide write, then readback of both halves
    step(0, "R7", 0, 3'd0, 0, 16'h0, 1, 32'h11223344, 3'd0, 0, 3'd2, 0);
    step(0, "R7", 0, 3'd0, 0, 16'h0, 0, '0, 3'd0, 0, 3'd2, 0);
    step(0, "R7", 0, 3'd0, 0, 16'h0, 0, '0, 3'd4, 1, 3'd6, 1);
    // R8: conflicts with word write to data reg, byte write to accumulator high, and a bystander
    step(0, "R8", 1, 3'd2, 0, 16'hFFFF, 1, 32'hCAFEF00D, 3'd2, 0, 3'd0, 0);
    step(0, "R8", 1, 3'd4, 1, 16'h0077, 1, 32'h0BAD1DEA, 3'd2, 0, 3'd0, 0);
    step(0, "R8", 1, 3'd3, 0, 16'h3C3C, 1, 32'h01020304, 3'd2, 0, 3'd0, 0);
    step(0, "R8", 0, 3'd0, 0, 16'h0, 0, '0, 3'd3, 0, 3'd0, 0);
    step(0, "R8", 0, 3'd0, 0, 16'h0, 0, '0, 3'd2, 0, 3'd4, 1);
    // R10: enables low with live-looking write inputs
    step(0, "R10", 0, 3'd3, 0, 16'h9999, 0, 32'h77777777, 3'd3, 0, 3'd0, 0);
    step(0, "R10", 0, 3'd6, 1, 16'h8888, 0, 32'h66666666, 3'd3, 0, 3'd2, 0);
    step(0, "R10", 0, 3'd0, 0, 16'h0, 0, '0, 3'd6, 0, 3'd7, 1);
    // R2: random mixed traffic
    for (int n = 0; n < 600; n++)
      step(0, "R2", 1'($urandom), 3'($urandom), 1'($urandom), 16'($urandom),
           ($urandom % 5) == 0, $urandom,
           3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom));
    // R1: reset mid-run, then every register reads zero
    step(1, "R1", 1, 3'd0, 0, 16'hAAAA, 0, '0, 3'd0, 0, 3'd1, 0);
    step(0, "R1", 0, 3'd0, 0, 16'h0, 0, '0, 3'd0, 0, 3'd1, 0);
    for (int i = 0; i < 8; i++)
      step(0, "R1", 0, 3'd0, 0, 16'h0, 0, '0, 3'(i), 0, 3'(i), 1);
    step(0, "R1", 0, 3'd0, 0, 16'h0, 0, '0, 3'd0, 0, 3'd0, 0);
    @(negedge clk);
    compare(cur_tag);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule